// File: doc/BRIEF.md
# Power Mode and Wake-Up Scheduler

This block decides when a capacitance measurement engine should run a conversion sequence. A two-bit mode input selects one of three behaviours. In full rate, sequences follow each other with no gap. In low power, one sequence runs after each programmable wait, counted in millisecond ticks, and its results feed the compensation logic. In shutdown, no sequence is started. While in low power, a proximity input promotes the scheduler to full-rate sequences. After proximity goes away, a small count of completed sequences has to pass before the wait-based operation resumes.

The measurement engine acknowledges each started sequence with a one-cycle done pulse. The scheduler treats that pulse as the sequence boundary. Mode changes between full rate and low power take effect only at a boundary. Shutdown takes effect at once and abandons any sequence in flight. Outputs are a start pulse, a reduced-power flag that a power manager can use to gate clocks, and the scheduler state.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, the state reads 1 (full rate), the start pulse is 0 and the reduced-power flag is 0.
- R2: The mode input decodes as follows: 00 selects full rate, 10 selects low power, and 01 or 11 selects shutdown. The state output encodes shutdown=0, full rate=1, low-power waiting=2, and promoted (proximity full rate)=3. Every start pulse is issued in state 1, 2 or 3.
- R3: One clock after mode bit 0 is high, the state is 0. While the state is 0, no start pulse occurs, and a done pulse, ticks or proximity have no effect.
- R4: When the mode leaves shutdown, the next clock enters state 1 with a start pulse if the mode is 00, or state 2 with no start pulse if the mode is 10.
- R5: In state 1 with mode 00, a start pulse appears in the cycle after each done pulse. The first start pulse after reset appears one cycle after reset is released.
- R6: In state 2 with no sequence running, a start pulse appears in the cycle after the K-th millisecond tick, with K = (delay code + 1) x STEP_MS. Ticks are counted from entry into state 2 or from the last done pulse. No start pulse appears before that tick.
- R7: The reduced-power flag is 1 exactly when the state is 2.
- R8: In state 2 with proximity high, the scheduler moves to state 3 and issues a start pulse. If no sequence is running, this happens on the next clock. If a sequence is running, it happens in the cycle after that sequence's done pulse.
- R9: In state 3, a done pulse that arrives while proximity is low returns the scheduler to state 2 with no start pulse once it is the N-th such done pulse since proximity was last high, with N = 1, 2, 4 or 8 for hold codes 00, 01, 10 and 11. Any other done pulse in state 3 gives a start pulse in the next cycle.
- R10: A change between modes 00 and 10 while a sequence runs takes effect only at that sequence's done pulse. From state 2 or 3, mode 00 enters state 1 with a start pulse at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| mode_sel | input | 2 | Power mode code |
| lp_delay_sel | input | 2 | Low-power wait code, (code+1) x STEP_MS ticks |
| hold_sel | input | HOLD_W | Hold code after proximity loss, 2^code sequences |
| prox | input | 1 | User proximity detected |
| seq_done | input | 1 | Pulse: current conversion sequence finished |
| seq_start | output | 1 | Pulse: begin a conversion sequence |
| low_pwr | output | 1 | Reduced-power state flag |
| state_o | output | 2 | Scheduler state |

## Verification
Several properties are checked on every cycle:
- shutdown takes hold one clock after the mode says so, and no pulse is issued while it lasts;
- full rate restarts in the cycle after each done;
- the waiting state stays quiet in any cycle without a tick, proximity or done;
- proximity promotes an idle scheduler at once;
- the wait counter and the hold counter stay within their ranges and reload correctly.

Other behaviour is shown only by the bench's scenarios:
- the exact tick on which a low-power sequence fires;
- counting the N-th done pulse after proximity is lost;
- deferring a mode change to the sequence boundary;
- promotion that waits for a running sequence to finish;
- the state in which every start pulse is issued.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_FULL     = 2'd1,
    ST_LP_IDLE  = 2'd2,
    ST_LP_AWAKE = 2'd3
  } pw_state_t;

  localparam logic [1:0] MODE_FULL = 2'b00;
  localparam logic [1:0] MODE_LOW  = 2'b10;

  function automatic logic mode_is_off(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/pwr_lp_timer.sv
module pwr_lp_timer #(
  parameter int STEP_MS = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ms_tick,
  input  logic [1:0] sel,
  output logic       fire
);
  localparam int MAXC = 4 * STEP_MS;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;

  assign limit_m1 = CW'((int'(sel) + 1) * STEP_MS - 1);
  // >= keeps a shortened wait from wrapping when sel drops mid-count
  assign fire = en && ms_tick && (cnt >= limit_m1);

  always_ff @(posedge clk) begin
    if (rst || !en)   cnt <= '0;
    else if (ms_tick) cnt <= fire ? '0 : cnt + 1'b1;
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < MAXC);

endmodule

// File: rtl/pwr_hold_ctr.sv
module pwr_hold_ctr #(
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [HOLD_W-1:0] sel,
  output logic              last
);
  localparam int MAXN = 1 << ((1 << HOLD_W) - 1);
  localparam int CW   = $clog2(MAXN + 1);

  logic [CW-1:0] cnt;

  assign last = (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= CW'(1);
    else if (load)            cnt <= CW'(1) << sel;
    else if (step && !last)   cnt <= cnt - 1'b1;
  end

  p_hold_load_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == (CW'(1) << $past(sel))));

  p_hold_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int STEP_MS = 200,
  parameter int HOLD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic [1:0]        mode_sel,
  input  logic [1:0]        lp_delay_sel,
  input  logic [HOLD_W-1:0] hold_sel,
  input  logic              prox,
  input  logic              seq_done,
  output logic              seq_start,
  output logic              low_pwr,
  output logic [1:0]        state_o
);
  pw_state_t st, st_n;
  logic      busy, busy_n, start_n;
  logic      boundary, lp_fire, hold_last;

  assign boundary = !busy || seq_done;
  assign state_o  = st;

  pwr_lp_timer #(.STEP_MS(STEP_MS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en      ((st == ST_LP_IDLE) && !busy),
    .ms_tick (ms_tick),
    .sel     (lp_delay_sel),
    .fire    (lp_fire)
  );

  pwr_hold_ctr #(.HOLD_W(HOLD_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (prox),
    .step ((st == ST_LP_AWAKE) && seq_done && !prox),
    .sel  (hold_sel),
    .last (hold_last)
  );

  always_comb begin
    st_n    = st;
    start_n = 1'b0;
    busy_n  = seq_done ? 1'b0 : busy;
    if (mode_is_off(mode_sel)) begin
      st_n   = ST_OFF;
      busy_n = 1'b0;
    end else begin
      unique case (st)
        ST_OFF: begin
          if (mode_sel == MODE_FULL) begin
            st_n    = ST_FULL;
            start_n = 1'b1;
          end else begin
            st_n = ST_LP_IDLE;
          end
        end
        ST_FULL: begin
          if (boundary) begin
            if (mode_sel == MODE_LOW) st_n = ST_LP_IDLE;
            else                      start_n = 1'b1;
          end
        end
        ST_LP_IDLE: begin
          if (boundary) begin
            if (mode_sel == MODE_FULL) begin
              st_n    = ST_FULL;
              start_n = 1'b1;
            end else if (prox) begin
              st_n    = ST_LP_AWAKE;
              start_n = 1'b1;
            end else if (lp_fire) begin
              start_n = 1'b1;
            end
          end
        end
        ST_LP_AWAKE: begin
          if (boundary) begin
            if (mode_sel == MODE_FULL) begin
              st_n    = ST_FULL;
              start_n = 1'b1;
            end else if (seq_done && !prox && hold_last) begin
              st_n = ST_LP_IDLE;
            end else begin
              start_n = 1'b1;
            end
          end
        end
        default: st_n = ST_OFF;
      endcase
    end
    if (start_n) busy_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FULL;
      busy      <= 1'b0;
      seq_start <= 1'b0;
      low_pwr   <= 1'b0;
    end else begin
      st        <= st_n;
      busy      <= busy_n;
      seq_start <= start_n;
      low_pwr   <= (st_n == ST_LP_IDLE);
    end
  end

  p_off_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF) |-> !seq_start);

  p_shutdown_now_r3: assert property (@(posedge clk) disable iff (rst)
    mode_sel[0] |=> (st == ST_OFF));

  p_full_b2b_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FULL && seq_done && mode_sel == MODE_FULL) |=> seq_start);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LP_IDLE && !ms_tick && !prox && !seq_done && mode_sel == MODE_LOW)
      |=> !seq_start);

  p_promote_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LP_IDLE && !busy && prox && mode_sel == MODE_LOW)
      |=> (st == ST_LP_AWAKE && seq_start));

endmodule

// File: tb/pwr_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_bench;
  localparam int STEP = 3;

  logic       clk = 1'b0, rst = 1'b1, ms_tick = 1'b0, prox = 1'b0, seq_done = 1'b0;
  logic [1:0] mode_sel = 2'b00, dly_sel = 2'b00, hold_sel = 2'b00;
  logic       seq_start, low_pwr;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];

  always #2.5 clk = ~clk;

  pwr_wake_ctrl #(.STEP_MS(STEP), .HOLD_W(2)) u_pwr_wake_ctrl (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .mode_sel(mode_sel),
    .lp_delay_sel(dly_sel), .hold_sel(hold_sel), .prox(prox),
    .seq_done(seq_done), .seq_start(seq_start), .low_pwr(low_pwr),
    .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_start(input logic [1:0] s);
    exp_q.push_back(s);
  endtask

  task automatic pulse_done();
    seq_done = 1'b1;
    step();
    seq_done = 1'b0;
  endtask

  task automatic ms(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      step();
      ms_tick = 1'b0;
      step();
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // scoreboard monitor: every start pulse must match a queued expectation (R2 state)
  always @(negedge clk) begin
    if (!rst && seq_start) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2 unexpected start pulse actual=1 expected=0 state=%0d", state_o);
      end else begin
        chk("R2 start issued in state", int'(state_o), int'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset state", state_o, 1);
    chk("R1 reset start", seq_start, 0);
    chk("R1 reset low_pwr", low_pwr, 0);
    rst = 1'b0;
    expect_start(2'd1);
    step();
    chk("R5 first start after reset", seq_start, 1);
    step();
    chk("R5 no start while busy", seq_start, 0);
    step(3);
    expect_start(2'd1);
    pulse_done();
    chk("R5 back-to-back start", seq_start, 1);

    // R10: switch to low power mid-sequence
    step();
    mode_sel = 2'b10;
    step(4);
    chk("R10 full kept until boundary", state_o, 1);
    chk("R7 low_pwr low in full", low_pwr, 0);
    pulse_done();
    chk("R10 low power at boundary", state_o, 2);
    chk("R7 low_pwr high when waiting", low_pwr, 1);
    chk("R10 no start entering wait", seq_start, 0);

    // R6: delay code 01 -> 6 ticks
    dly_sel = 2'b01;
    ms(5);
    chk("R6 no start before K ticks", seq_start, 0);
    expect_start(2'd2);
    ms_tick = 1'b1;
    step();
    ms_tick = 1'b0;
    chk("R6 start after K-th tick", seq_start, 1);
    step();
    chk("R6 single pulse", seq_start, 0);
    pulse_done();
    chk("R6 back to waiting", state_o, 2);

    // R8/R9: promotion, hold code 01 -> 2 sequences
    hold_sel = 2'b01;
    prox = 1'b1;
    expect_start(2'd3);
    step();
    chk("R8 promoted state", state_o, 3);
    chk("R8 promotion start", seq_start, 1);
    chk("R7 low_pwr low when promoted", low_pwr, 0);
    step(2);
    expect_start(2'd3);
    pulse_done();
    chk("R9 full rate with prox", seq_start, 1);
    prox = 1'b0;
    step();
    expect_start(2'd3);
    pulse_done();
    chk("R9 first done after loss continues", state_o, 3);
    pulse_done();
    chk("R9 second done returns to wait", state_o, 2);
    chk("R9 no start on return", seq_start, 0);

    // R9: hold code 00 -> 1 sequence
    hold_sel = 2'b00;
    prox = 1'b1;
    expect_start(2'd3);
    step();
    chk("R8 promoted again", state_o, 3);
    prox = 1'b0;
    pulse_done();
    chk("R9 single-sequence hold", state_o, 2);

    // R8 while a low-power sequence runs; delay code 00 -> 3 ticks
    dly_sel = 2'b00;
    expect_start(2'd2);
    ms(3);
    chk("R6 short delay still waiting", state_o, 2);
    prox = 1'b1;
    step(2);
    chk("R8 promotion waits for boundary", state_o, 2);
    expect_start(2'd3);
    pulse_done();
    chk("R8 promoted at boundary", state_o, 3);
    prox = 1'b0;
    pulse_done();
    chk("R9 hold done", state_o, 2);

    // R3: shutdown ignores everything
    mode_sel = 2'b11;
    step();
    chk("R3 shutdown code 11", state_o, 0);
    chk("R7 low_pwr low in shutdown", low_pwr, 0);
    prox = 1'b1;
    ms(4);
    pulse_done();
    prox = 1'b0;
    mode_sel = 2'b01;
    step(2);
    chk("R3 shutdown code 01", state_o, 0);

    // R4: leave shutdown
    mode_sel = 2'b00;
    expect_start(2'd1);
    step();
    chk("R4 exit to full", state_o, 1);
    chk("R4 start on exit", seq_start, 0 + 1);
    mode_sel = 2'b01;
    step();
    chk("R3 immediate shutdown mid-sequence", state_o, 0);
    pulse_done();
    chk("R3 done ignored in shutdown", seq_start, 0);
    mode_sel = 2'b10;
    step();
    chk("R4 exit to low power", state_o, 2);
    chk("R4 no start entering low power", seq_start, 0);

    // R10: waiting -> full
    mode_sel = 2'b00;
    expect_start(2'd1);
    step();
    chk("R10 wait to full", state_o, 1);
    chk("R10 start on switch", seq_start, 1);

    step(2);
    chk("R2 all expected starts seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule